// File: doc/BRIEF.md
# I2C Bus Event Trigger

This block watches a two-wire I2C bus without driving it and emits a single-cycle trigger when a chosen bus event occurs. It brings both wires into the system clock domain through a three-flop synchronizer and finds their edges. From those edges it recognises bus conditions and reassembles bytes. An event-select code picks what fires the trigger: a start from idle, a repeated start, a stop, a missing acknowledge, an address hit, a data hit, or an address hit followed by a data hit within one transfer. Address comparison works in 7-bit or 10-bit form.

Typical use is as the capture qualifier of a logic-analysis or debug path. Software-free configuration inputs (`ev_sel`, `addr_val`, `addr_10b`, `data_val`) are held steady while the bus is observed. The system clock must run at least eight times the bus bit rate, so buses up to 10 Mb/s need an 80 MHz or faster clock. The reset input is asynchronous and active low, and its release is resynchronized inside the block.

Top module: `i2c_event_trigger`

## Requirements
- R1: While reset is active and after its release with an idle bus (both lines high), `trig_out` is low.
- R2: Each line passes through three flops. A start with `ev_sel`=0 raises `trig_out` on the third rising clock edge after the SDA fall is first presented to the block.
- R3: `ev_sel`=0 fires on a start (SDA falling while SCL is high) only when no transfer is open. A start inside an open transfer does not fire it.
- R4: `ev_sel`=1 fires on a start seen while a transfer is open, that is after a start and before the next stop.
- R5: `ev_sel`=2 fires on a stop (SDA rising while SCL is high). The stop closes the transfer.
- R6: Bits are taken on SCL rising edges, MSB first. The ninth rise of each byte is the acknowledge slot. `ev_sel`=3 fires when SDA is high in that slot, for any byte.
- R7: `ev_sel`=4 with `addr_10b`=0 fires at the acknowledge slot of the first byte after a start when that byte's bits 7:1 equal `addr_val[6:0]`. Bit 0 (read/write) is ignored.
- R8: `ev_sel`=4 with `addr_10b`=1 fires at the acknowledge slot of the second byte. It needs two things: the first byte's bits 7:3 were 11110 and its bits 2:1 equal `addr_val[9:8]`, and the second byte equals `addr_val[7:0]`.
- R9: `ev_sel`=5 fires at the acknowledge slot of any data byte equal to `data_val`. Data bytes are those after the first byte in 7-bit mode and after the second byte in 10-bit mode. Address bytes never fire it.
- R10: `ev_sel`=6 fires on a data match (as in R9) only if an address match (as in R7/R8) occurred since the most recent start. Any start or stop clears that record.
- R11: Any start or stop discards a partly received byte and restarts bit and byte counting, so the next byte is treated as the first byte.
- R12: `trig_out` is one clock wide. Byte-based events never fire before the acknowledge slot, and code 7 never fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous to clk |
| sda_in | input | 1 | Bus data line, asynchronous to clk |
| ev_sel | input | 3 | Trigger event code: 0 start, 1 repeated start, 2 stop, 3 missing ACK, 4 address, 5 data, 6 address then data, 7 none |
| addr_val | input | 10 | Address to match; bits 6:0 used in 7-bit mode |
| addr_10b | input | 1 | 1 selects 10-bit address matching |
| data_val | input | 8 | Data byte to match |
| trig_out | output | 1 | One-cycle trigger pulse |

## Verification
A missing acknowledge and an address hit are both decided on the same SCL rise: the ninth edge of the address byte. The bench provokes this collision by sending a matching address byte whose acknowledge bit is left high. It replays that identical transfer once with the missing-ACK code and once with the address code. Each run must yield exactly one pulse, which shows that sharing a slot does not make either event mask the other. Pulse counts are taken over whole transfers, and the pulse count is also checked just before the acknowledge slot.

// File: rtl/i2c_trig_pkg.sv
package i2c_trig_pkg;

  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_RESTART   = 3'd1,
    EV_STOP      = 3'd2,
    EV_NOACK     = 3'd3,
    EV_ADDR      = 3'd4,
    EV_DATA      = 3'd5,
    EV_ADDR_DATA = 3'd6,
    EV_NONE      = 3'd7
  } trig_sel_e;

  typedef struct packed {
    logic start;
    logic restart;
    logic stop;
    logic noack;
    logic addr_hit;
    logic data_hit;
    logic pair_hit;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_q,
  output logic line_prev
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;
  logic [LAST:0] stage_d;

  always_comb begin
    stage_d = {stage_q[LAST-1:0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign line_q    = stage_q[LAST-1];
  assign line_prev = stage_q[LAST];

  // R2
  stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_prev == $past(line_q));

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_open,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic              start_c,
  input  logic              stop_c,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ack_bit,
  output logic [IDX_W-1:0]  byte_idx
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              done_c;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    done_c = 1'b0;
    if (start_c || stop_c) begin
      cnt_d = '0;
      sh_d  = '0;
      idx_d = '0;
    end else if (scl_rise && xfer_open) begin
      if (cnt_q == ACK_SLOT) begin
        done_c = 1'b1;
        cnt_d  = '0;
        if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
      end else begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign byte_done = done_c;
  assign byte_val  = sh_q;
  assign ack_bit   = sda_s;
  assign byte_idx  = idx_q;

  // R11
  abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> (cnt_q == '0 && idx_q == '0));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_SLOT);

endmodule

// File: rtl/i2c_match_unit.sv
module i2c_match_unit #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              addr_10b,
  input  logic [BYTE_W-1:0] data_val,
  output logic              addr_hit,
  output logic              data_hit,
  output logic              pair_hit
);

  localparam logic [4:0] HDR10 = 5'b11110;

  logic hi_ok_q, hi_ok_d;
  logic addr_ok_q, addr_ok_d;
  logic hdr_match, first_b, second_b, data_phase;

  always_comb begin
    first_b    = (byte_idx == IDX_W'(0));
    second_b   = (byte_idx == IDX_W'(1));
    data_phase = addr_10b ? (byte_idx >= IDX_W'(2)) : !first_b;
    hdr_match  = (byte_val[7:3] == HDR10) && (byte_val[2:1] == addr_val[9:8]);
    addr_hit   = byte_done && (addr_10b
                 ? (second_b && hi_ok_q && byte_val == addr_val[7:0])
                 : (first_b && byte_val[7:1] == addr_val[6:0]));
    data_hit   = byte_done && data_phase && (byte_val == data_val);
    pair_hit   = data_hit && addr_ok_q;

    hi_ok_d   = hi_ok_q;
    addr_ok_d = addr_ok_q;
    if (start_c || stop_c) begin
      hi_ok_d   = 1'b0;
      addr_ok_d = 1'b0;
    end else begin
      if (byte_done && first_b) hi_ok_d = hdr_match;
      if (addr_hit)             addr_ok_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ok_q   <= 1'b0;
      addr_ok_q <= 1'b0;
    end else begin
      hi_ok_q   <= hi_ok_d;
      addr_ok_q <= addr_ok_d;
    end
  end

  // R10
  pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !addr_ok_q);

  // R9
  data_not_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |-> (byte_idx != IDX_W'(0)));

endmodule

// File: rtl/i2c_event_trigger.sv
module i2c_event_trigger
  import i2c_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 3,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 10,
  parameter int IDX_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        ev_sel,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              addr_10b,
  input  logic [BYTE_W-1:0] data_val,
  output logic              trig_out
);

  localparam int NLINES = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NLINES-1:0] raw_in, lq, lp;
  assign raw_in = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_ni),
      .line_in   (raw_in[g]),
      .line_q    (lq[g]),
      .line_prev (lp[g])
    );
  end

  logic scl_s, scl_rise, sda_s, start_c, stop_c;
  assign scl_s    = lq[0];
  assign scl_rise = lq[0] & ~lp[0];
  assign sda_s    = lq[1];
  assign start_c  = scl_s & lp[1] & ~lq[1];
  assign stop_c   = scl_s & ~lp[1] & lq[1];

  logic open_q, open_d;
  always_comb begin
    open_d = open_q;
    if (stop_c)       open_d = 1'b0;
    else if (start_c) open_d = 1'b1;
  end

  logic              byte_done, ack_bit;
  logic [BYTE_W-1:0] byte_val;
  logic [IDX_W-1:0]  byte_idx;

  i2c_bit_engine #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_ni),
    .xfer_open (open_q),
    .scl_rise  (scl_rise),
    .sda_s     (sda_s),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .ack_bit   (ack_bit),
    .byte_idx  (byte_idx)
  );

  bus_evt_t evt;

  i2c_match_unit #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .byte_idx  (byte_idx),
    .addr_val  (addr_val),
    .addr_10b  (addr_10b),
    .data_val  (data_val),
    .addr_hit  (evt.addr_hit),
    .data_hit  (evt.data_hit),
    .pair_hit  (evt.pair_hit)
  );

  assign evt.start   = start_c & ~open_q;
  assign evt.restart = start_c & open_q;
  assign evt.stop    = stop_c;
  assign evt.noack   = byte_done & ack_bit;

  trig_sel_e sel;
  logic      trig_q, trig_d;
  assign sel = trig_sel_e'(ev_sel);

  always_comb begin
    unique case (sel)
      EV_START:     trig_d = evt.start;
      EV_RESTART:   trig_d = evt.restart;
      EV_STOP:      trig_d = evt.stop;
      EV_NOACK:     trig_d = evt.noack;
      EV_ADDR:      trig_d = evt.addr_hit;
      EV_DATA:      trig_d = evt.data_hit;
      EV_ADDR_DATA: trig_d = evt.pair_hit;
      default:      trig_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      open_q <= open_d;
      trig_q <= trig_d;
    end
  end

  assign trig_out = trig_q;

  // R12
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    trig_q |=> !trig_q);

  // R3
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_c && !stop_c) |=> open_q);

  // R5
  stop_closes_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_c |=> !open_q);

  // R12
  byte_only_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt.addr_hit || evt.data_hit || evt.noack) |-> scl_rise);

endmodule

// File: tb/i2c_event_trigger_tb.sv
module i2c_event_trigger_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_in, sda_in;
  logic [2:0] ev_sel;
  logic [9:0] addr_val;
  logic       addr_10b;
  logic [7:0] data_val;
  logic       trig_out;

  int vectors = 0;
  int misses  = 0;
  int pulses  = 0;
  int wide    = 0;
  bit trig_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_event_trigger u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .ev_sel   (ev_sel),
    .addr_val (addr_val),
    .addr_10b (addr_10b),
    .data_val (data_val),
    .trig_out (trig_out)
  );

  always @(negedge clk) begin
    if (trig_out) pulses++;
    if (trig_out && trig_prev) wide++;
    trig_prev = trig_out;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_in = 1'b1; waitq(Q);
    scl_in = 1'b1; waitq(Q);
    sda_in = 1'b0; waitq(Q);
    scl_in = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_in = 1'b0; waitq(Q);
    scl_in = 1'b1; waitq(Q);
    sda_in = 1'b1; waitq(2*Q);
  endtask

  task automatic bus_bit(input bit b);
    sda_in = b;    waitq(Q);
    scl_in = 1'b1; waitq(2*Q);
    scl_in = 1'b0; waitq(Q);
  endtask

  task automatic bus_byte(input logic [7:0] b, input bit nack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(nack);
  endtask

  task automatic expect_count(input int base, input int exp, input string tag);
    waitq(6);
    check((pulses - base) == exp, tag, pulses - base, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    ev_sel = 3'd0; addr_val = '0; addr_10b = 1'b0; data_val = '0;
    waitq(5);
    check(trig_out == 1'b0, "R1 in reset", trig_out, 0);
    rst_n = 1'b1;
    waitq(8);
    check(trig_out == 1'b0, "R1 after reset", trig_out, 0);
  endtask

  task automatic t_latency();
    int n = 0;
    ev_sel = 3'd0;
    sda_in = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); n++;
      if (trig_out) break;
    end
    check(n == 3, "R2 start latency", n, 3);
    waitq(Q);
    scl_in = 1'b0; waitq(Q);
    bus_stop();
  endtask

  task automatic restart_txn();
    bus_start(); bus_byte(8'hA0, 1'b0);
    bus_start(); bus_byte(8'hA1, 1'b0);
    bus_stop();
  endtask

  task automatic t_conditions();
    int b;
    ev_sel = 3'd0; b = pulses; restart_txn(); expect_count(b, 1, "R3 start only from idle");
    ev_sel = 3'd1; b = pulses; restart_txn(); expect_count(b, 1, "R4 repeated start");
    ev_sel = 3'd2; b = pulses; restart_txn(); expect_count(b, 1, "R5 stop");
    ev_sel = 3'd7; b = pulses; restart_txn(); expect_count(b, 0, "R12 code 7 silent");
  endtask

  task automatic t_noack();
    int b;
    ev_sel = 3'd3; b = pulses;
    bus_start(); bus_byte(8'hA0, 1'b0); bus_byte(8'h55, 1'b1); bus_stop();
    expect_count(b, 1, "R6 missing ack on data byte");
  endtask

  task automatic t_addr7();
    int b;
    ev_sel = 3'd4; addr_10b = 1'b0; addr_val = 10'h050; b = pulses;
    bus_start();
    for (int i = 7; i >= 0; i--) bus_bit(8'hA1 >> i);
    check(pulses == b, "R12 no hit before ack slot", pulses - b, 0);
    bus_bit(1'b0);
    bus_byte(8'hA0, 1'b0); bus_stop();
    expect_count(b, 1, "R7 7-bit address match");
    addr_val = 10'h051; b = pulses;
    bus_start(); bus_byte(8'hA1, 1'b0); bus_stop();
    expect_count(b, 0, "R7 7-bit address mismatch");
  endtask

  task automatic t_addr10();
    int b;
    ev_sel = 3'd4; addr_10b = 1'b1; addr_val = 10'h2A5; b = pulses;
    bus_start(); bus_byte(8'hF4, 1'b0); bus_byte(8'hA5, 1'b0); bus_byte(8'h00, 1'b0); bus_stop();
    expect_count(b, 1, "R8 10-bit address match");
    b = pulses;
    bus_start(); bus_byte(8'hF4, 1'b0); bus_byte(8'hA4, 1'b0); bus_stop();
    expect_count(b, 0, "R8 10-bit low byte mismatch");
    b = pulses;
    bus_start(); bus_byte(8'hF2, 1'b0); bus_byte(8'hA5, 1'b0); bus_stop();
    expect_count(b, 0, "R8 10-bit high bits mismatch");
  endtask

  task automatic t_data();
    int b;
    ev_sel = 3'd5; addr_10b = 1'b0; data_val = 8'h3C; b = pulses;
    bus_start(); bus_byte(8'h3C, 1'b0); bus_byte(8'h11, 1'b0); bus_byte(8'h3C, 1'b0); bus_stop();
    expect_count(b, 1, "R9 data match 7-bit, address byte ignored");
    addr_10b = 1'b1; b = pulses;
    bus_start(); bus_byte(8'hF4, 1'b0); bus_byte(8'h3C, 1'b0); bus_byte(8'h3C, 1'b0); bus_stop();
    expect_count(b, 1, "R9 data match 10-bit, second byte ignored");
  endtask

  task automatic t_pair();
    int b;
    ev_sel = 3'd6; addr_10b = 1'b0; addr_val = 10'h050; data_val = 8'h3C; b = pulses;
    bus_start(); bus_byte(8'hA0, 1'b0); bus_byte(8'h3C, 1'b0); bus_stop();
    expect_count(b, 1, "R10 address then data");
    b = pulses;
    bus_start(); bus_byte(8'hA2, 1'b0); bus_byte(8'h3C, 1'b0); bus_stop();
    expect_count(b, 0, "R10 wrong address");
    b = pulses;
    bus_start(); bus_byte(8'hA0, 1'b0);
    bus_start(); bus_byte(8'hA2, 1'b0); bus_byte(8'h3C, 1'b0); bus_stop();
    expect_count(b, 0, "R10 repeated start clears address hit");
  endtask

  task automatic t_abort();
    int b;
    ev_sel = 3'd4; addr_10b = 1'b0; addr_val = 10'h050; b = pulses;
    bus_start(); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start(); bus_byte(8'hA0, 1'b0); bus_stop();
    expect_count(b, 1, "R11 restart aborts partial byte");
    b = pulses;
    bus_start(); bus_bit(1'b0); bus_bit(1'b1); bus_stop();
    bus_start(); bus_byte(8'hA0, 1'b0); bus_stop();
    expect_count(b, 1, "R11 stop aborts partial byte");
  endtask

  task automatic t_collide();
    int b;
    addr_10b = 1'b0; addr_val = 10'h050;
    ev_sel = 3'd3; b = pulses;
    bus_start(); bus_byte(8'hA0, 1'b1); bus_stop();
    expect_count(b, 1, "R6 nack on matching address");
    ev_sel = 3'd4; b = pulses;
    bus_start(); bus_byte(8'hA0, 1'b1); bus_stop();
    expect_count(b, 1, "R7 address hit with nack");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_conditions();
    t_noack();
    t_addr7();
    t_addr10();
    t_data();
    t_pair();
    t_abort();
    t_collide();
    check(wide == 0, "R12 pulse width", wide, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; misses++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule